// File: doc/BRIEF.md
# Broadcast Lane Instruction Queue Hub

This block sits between two scalar control issuers and a pool of vector compute lanes. Every lane owns an instruction FIFO. A lane map says which issuer, if any, each lane belongs to. When an issuer dispatches a vector instruction, the same word lands in the FIFO of every lane it owns, in one cycle. Each lane then drains its own FIFO through a ready/valid handshake at whatever rate it can execute. The scalar side can therefore run ahead of its lanes by up to one queue depth.

An issuer is held off while any of its lanes has a full queue that is not draining in that cycle. A lane that owns an instruction queue with nothing in it reports a stall. The lane map can be changed at run time to move lanes between issuers. Each issuer's resulting vector width is reported as its lane count times the per-lane SIMD width. A map change waits until every lane it touches is empty.

Top module: `vlane_dispatch_hub`

## Requirements
- R1: A dispatch accepted from an issuer (valid high, stall low) is written into the queue of every lane mapped to that issuer at the same clock edge. From the next cycle those lanes present it.
- R2: Each lane pops its own queue when lane_valid and lane_ready are both high, independently of the other lanes. Words leave in the order they were written. While valid is high and ready is low, the presented word holds.
- R3: The stall output of an issuer is high exactly when at least one lane mapped to it has a full queue and lane_ready low. While the stall is high, no word from that issuer is stored.
- R4: A mapped lane with an empty queue drives lane_stall high and lane_valid low.
- R5: The lane map has 2 bits per lane, with lane i at bits [2i+1:2i]. Code 01 selects issuer 0, code 10 selects issuer 1, and 00 or 11 leaves the lane unassigned. An accepted request takes effect on cur_map at the next edge. Without an accepted request, cur_map holds.
- R6: An unassigned lane ignores all dispatches, keeps lane_valid and lane_stall low, and does not affect either stall.
- R7: iss0_width and iss1_width equal SIMD times the number of lanes mapped to issuer 0 and issuer 1.
- R8: A map request is accepted only if every lane whose code changes has an empty queue and receives no word in that cycle. Otherwise cfg_busy is high and the map is kept.
- R9: A full queue that pops in a cycle also accepts a dispatch in that cycle, and its occupancy stays the same.
- R10: After reset all queues are empty, every lane is unassigned, and the stalls, busy and widths are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss0_valid | input | 1 | Issuer 0 dispatch request |
| iss0_instr | input | WORD | Issuer 0 instruction word |
| iss0_stall | output | 1 | Issuer 0 held off |
| iss1_valid | input | 1 | Issuer 1 dispatch request |
| iss1_instr | input | WORD | Issuer 1 instruction word |
| iss1_stall | output | 1 | Issuer 1 held off |
| iss0_width | output | clog2(LANES*SIMD+1) | Vector width owned by issuer 0 |
| iss1_width | output | clog2(LANES*SIMD+1) | Vector width owned by issuer 1 |
| cfg_req | input | 1 | Request to load a new lane map |
| cfg_map | input | 2*LANES | Requested lane map |
| cfg_busy | output | 1 | Request refused this cycle |
| cur_map | output | 2*LANES | Lane map in force |
| lane_valid | output | LANES | Lane queue has a word |
| lane_instr | output | LANES*WORD | Head word per lane, lane i at bits [WORD*i +: WORD] |
| lane_ready | input | LANES | Lane takes its head word |
| lane_stall | output | LANES | Mapped lane waiting on an empty queue |

## Verification
Two cases need care because two functions fall in the same cycle. The first is a pop and a dispatch on a full queue. The bench fills the queues of issuer 0 with all readies low, then raises the readies of those lanes while issuer 0 keeps dispatching. The stall must stay low and the occupancy must stay the same. The second is a map request that arrives in the same cycle as a dispatch into a lane it changes. The bench drains all queues, then requests a swap while issuer 0 dispatches, and expects cfg_busy with the old map kept. A behavioural queue model compares every output on every clock, including long random stretches with random map requests.

// File: rtl/vlane_dispatch_hub.sv
module vlane_dispatch_hub #(
  parameter int LANES = 8,
  parameter int DEPTH = 24,
  parameter int WORD  = 32,
  parameter int SIMD  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss0_valid,
  input  logic [WORD-1:0]         iss0_instr,
  output logic                    iss0_stall,
  input  logic                    iss1_valid,
  input  logic [WORD-1:0]         iss1_instr,
  output logic                    iss1_stall,
  output logic [$clog2(LANES*SIMD+1)-1:0] iss0_width,
  output logic [$clog2(LANES*SIMD+1)-1:0] iss1_width,
  input  logic                    cfg_req,
  input  logic [2*LANES-1:0]      cfg_map,
  output logic                    cfg_busy,
  output logic [2*LANES-1:0]      cur_map,
  output logic [LANES-1:0]        lane_valid,
  output logic [LANES*WORD-1:0]   lane_instr,
  input  logic [LANES-1:0]        lane_ready,
  output logic [LANES-1:0]        lane_stall
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = $clog2(DEPTH);
  localparam int WW = $clog2(LANES*SIMD+1);

  logic [2*LANES-1:0] map_q;
  logic [LANES-1:0] own0, own1, full, push, pop, changed;
  logic go0, go1, cfg_ok;

  assign iss0_stall = |(own0 & full & ~lane_ready);
  assign iss1_stall = |(own1 & full & ~lane_ready);
  assign go0 = iss0_valid & ~iss0_stall;
  assign go1 = iss1_valid & ~iss1_stall;
  assign cfg_ok   = ~|(changed & (lane_valid | push));
  assign cfg_busy = cfg_req & ~cfg_ok;
  assign cur_map  = map_q;
  assign iss0_width = WW'($countones(own0) * SIMD);
  assign iss1_width = WW'($countones(own1) * SIMD);

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else if (cfg_req && cfg_ok) map_q <= cfg_map;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign own0[i]    = map_q[2*i +: 2] == 2'b01;
    assign own1[i]    = map_q[2*i +: 2] == 2'b10;
    assign changed[i] = cfg_map[2*i +: 2] != map_q[2*i +: 2];
    assign push[i]    = (own0[i] & go0) | (own1[i] & go1);
    assign pop[i]     = lane_valid[i] & lane_ready[i];
    assign full[i]    = cnt == CW'(DEPTH);
    assign lane_valid[i] = cnt != '0;
    assign lane_stall[i] = (own0[i] | own1[i]) & (cnt == '0);
    assign lane_instr[i*WORD +: WORD] = mem[rp];

    always_ff @(posedge clk) begin
      if (push[i]) mem[wp] <= own1[i] ? iss1_instr : iss0_instr;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push[i]) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (pop[i])  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push[i]) - CW'(pop[i]);
      end
    end
  end
endmodule

// File: rtl/vlane_dispatch_hub_chk.sv
module vlane_dispatch_hub_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 24,
  parameter int WORD  = 32,
  parameter int SIMD  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss0_valid,
  input logic [WORD-1:0]         iss0_instr,
  input logic                    iss0_stall,
  input logic                    iss1_valid,
  input logic [WORD-1:0]         iss1_instr,
  input logic                    iss1_stall,
  input logic [$clog2(LANES*SIMD+1)-1:0] iss0_width,
  input logic [$clog2(LANES*SIMD+1)-1:0] iss1_width,
  input logic                    cfg_req,
  input logic [2*LANES-1:0]      cfg_map,
  input logic                    cfg_busy,
  input logic [2*LANES-1:0]      cur_map,
  input logic [LANES-1:0]        lane_valid,
  input logic [LANES*WORD-1:0]   lane_instr,
  input logic [LANES-1:0]        lane_ready,
  input logic [LANES-1:0]        lane_stall
);
  // R8
  busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |-> cfg_req);

  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && !cfg_busy) |=> $stable(cur_map));

  // R5
  map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_busy) |=> cur_map == $past(cfg_map));

  // R7
  width_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(iss0_width) + 32'(iss1_width)) <= LANES*SIMD);

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R6
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_map[2*i +: 2] == 2'b00 || cur_map[2*i +: 2] == 2'b11)
        |-> !lane_valid[i] && !lane_stall[i]);

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[i] && !lane_ready[i])
        |=> lane_valid[i] && $stable(lane_instr[i*WORD +: WORD]));

    // R4
    empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_stall[i] |-> !lane_valid[i]);
  end
endmodule

bind vlane_dispatch_hub vlane_dispatch_hub_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .WORD(WORD), .SIMD(SIMD)
) u_chk (.*);

// File: tb/sim_vlane_dispatch_hub.sv
`timescale 1ns/1ps
module sim_vlane_dispatch_hub;
  localparam int LANES = 8;
  localparam int DEPTH = 24;
  localparam int WORD  = 32;
  localparam int SIMD  = 4;
  localparam int WW    = $clog2(LANES*SIMD+1);

  logic clk = 0, rst_n = 0;
  logic iss0_valid = 0, iss1_valid = 0;
  logic [WORD-1:0] iss0_instr = 0, iss1_instr = 0;
  logic iss0_stall, iss1_stall, cfg_busy;
  logic [WW-1:0] iss0_width, iss1_width;
  logic cfg_req = 0;
  logic [2*LANES-1:0] cfg_map = 0, cur_map;
  logic [LANES-1:0] lane_valid, lane_stall, lane_ready = 0;
  logic [LANES*WORD-1:0] lane_instr;

  always #2.5 clk = ~clk;

  vlane_dispatch_hub #(.LANES(LANES), .DEPTH(DEPTH), .WORD(WORD), .SIMD(SIMD)) u0 (.*);

  int compared = 0, mismatched = 0;
  int m_map [LANES];
  int m_cnt [LANES];
  int m_head[LANES];
  logic [WORD-1:0] m_mem [LANES][DEPTH];
  logic [23:0] seq0 = 0, seq1 = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2*LANES-1:0] pack(input int c [LANES]);
    logic [2*LANES-1:0] r = '0;
    for (int i = 0; i < LANES; i++) r[2*i +: 2] = 2'(c[i]);
    return r;
  endfunction

  task automatic step(input logic v0, input logic v1, input logic [LANES-1:0] rdy,
                      input logic req, input logic [2*LANES-1:0] nmap);
    logic st0, st1, go0, go1, ok;
    logic [LANES-1:0] psh;
    int n0, n1;
    @(negedge clk);
    iss0_valid = v0; iss1_valid = v1;
    iss0_instr = {8'hA0, seq0}; iss1_instr = {8'hB1, seq1};
    lane_ready = rdy; cfg_req = req; cfg_map = nmap;
    #1;
    st0 = 0; st1 = 0; n0 = 0; n1 = 0;
    for (int i = 0; i < LANES; i++) begin
      if (m_map[i] == 1) n0++;
      if (m_map[i] == 2) n1++;
      if (m_map[i] == 1 && m_cnt[i] == DEPTH && !rdy[i]) st0 = 1;
      if (m_map[i] == 2 && m_cnt[i] == DEPTH && !rdy[i]) st1 = 1;
    end
    go0 = v0 & !st0; go1 = v1 & !st1;
    ok = 1;
    for (int i = 0; i < LANES; i++) begin
      psh[i] = (m_map[i] == 1 && go0) || (m_map[i] == 2 && go1);
      if (int'(nmap[2*i +: 2]) != m_map[i] && (m_cnt[i] != 0 || psh[i])) ok = 0;
    end
    chk("R3 iss0_stall", 64'(iss0_stall), 64'(st0));
    chk("R3 iss1_stall", 64'(iss1_stall), 64'(st1));
    chk("R8 cfg_busy", 64'(cfg_busy), 64'(req & !ok));
    chk("R5 cur_map", 64'(cur_map), 64'(pack(m_map)));
    chk("R7 iss0_width", 64'(iss0_width), 64'(n0 * SIMD));
    chk("R7 iss1_width", 64'(iss1_width), 64'(n1 * SIMD));
    for (int i = 0; i < LANES; i++) begin
      chk("R4 R6 lane_valid", 64'(lane_valid[i]), 64'(m_cnt[i] != 0));
      chk("R4 R6 lane_stall", 64'(lane_stall[i]),
          64'((m_map[i] == 1 || m_map[i] == 2) && m_cnt[i] == 0));
      if (m_cnt[i] != 0)
        chk("R1 R2 lane_instr", 64'(lane_instr[i*WORD +: WORD]), 64'(m_mem[i][m_head[i]]));
    end
    for (int i = 0; i < LANES; i++) begin
      if (m_cnt[i] != 0 && rdy[i]) begin
        m_head[i] = (m_head[i] + 1) % DEPTH;
        m_cnt[i]--;
      end
      if (psh[i]) begin
        m_mem[i][(m_head[i] + m_cnt[i]) % DEPTH] = (m_map[i] == 1) ? iss0_instr : iss1_instr;
        m_cnt[i]++;
      end
    end
    if (req && ok)
      for (int i = 0; i < LANES; i++) m_map[i] = int'(nmap[2*i +: 2]);
    seq0++; seq1++;
  endtask

  initial begin
    int split [LANES];
    int swap  [LANES];
    int other [LANES];
    for (int i = 0; i < LANES; i++) begin
      m_map[i] = 0; m_cnt[i] = 0; m_head[i] = 0;
      split[i] = (i < 3) ? 1 : 2;
      swap[i]  = (i < 3) ? 2 : 1;
      other[i] = (i < 2) ? 1 : (i < LANES-1) ? 2 : 0;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 iss0_stall", 64'(iss0_stall), 0);
    chk("R10 cfg_busy", 64'(cfg_busy), 0);
    chk("R10 cur_map", 64'(cur_map), 0);
    chk("R10 lane_valid", 64'(lane_valid), 0);
    chk("R10 iss0_width", 64'(iss0_width), 0);
    @(negedge clk); rst_n = 1;
    // R6: dispatches with no lanes mapped are dropped
    repeat (4) step(1, 1, '0, 0, '0);
    // R5 R7: three lanes to issuer 0, five to issuer 1
    step(0, 0, '0, 1, pack(split));
    repeat (400) step($urandom_range(0,9) < 7, $urandom_range(0,9) < 7,
                      LANES'($urandom), 0, '0);
    // R3: fill issuer 0 queues
    repeat (DEPTH + 8) step(1, 0, '0, 0, '0);
    // R9: full queues pop and push together
    repeat (10) step(1, 0, LANES'(8'b0000_0111), 0, '0);
    // R8: swap request while queues are occupied, then drained
    repeat (3) step(0, 0, '0, 1, pack(swap));
    repeat (DEPTH + 6) step(0, 0, '1, 1, pack(swap));
    // R8: empty queues but a dispatch lands in a changing lane
    repeat (DEPTH + 2) step(0, 0, '1, 0, '0);
    step(1, 0, '1, 1, pack(split));
    step(0, 0, '1, 1, pack(other));
    // R1 R2 R6: mixed traffic with random map requests
    repeat (1500) step($urandom_range(0,9) < 8, $urandom_range(0,9) < 5,
                       LANES'($urandom) | LANES'($urandom),
                       $urandom_range(0,19) == 0, 2*LANES'($urandom));
    repeat (300) step(1, 1, LANES'($urandom) & LANES'($urandom), 0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule